// File: doc/BRIEF.md
# Paired UART Transmit/Receive Queues with Level Interrupts

This block holds the character traffic between a UART's serial engines and the processor side. It has two queues: a transmit queue of 8-bit characters and a receive queue of 12-bit entries. Each receive entry is 8 data bits with 4 error flag bits above them. Both queues use a push/pop handshake. The read side is show-ahead: the oldest entry is always on the read data port while the queue is not empty.

A single mode input chooses how deep the queues are. With the input low, each direction acts as a one-entry holding register. With it high, each direction is a 16-entry first-in first-out queue. Changing the mode at run time empties both queues.

Each direction has its own interrupt request. In queue mode the request follows a fill threshold, set separately per direction in eighths of the depth. In holding mode the thresholds are ignored. A sticky overrun flag records a receive push that arrived while the receive side had no room.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset the block is in holding mode. Both queues are empty and neither is full, `overrun` is 0, `tx_irq` is 1 and `rx_irq` is 0.
- R2: With `fifo_en` high, each queue holds up to 16 entries and hands them out in arrival order. The full flag rises only when the 16th entry is held. A push into a full queue is dropped and leaves the contents unchanged.
- R3: With `fifo_en` low, a queue is full while it holds one entry, and a further push is dropped.
- R4: All 12 bits of a receive entry and all 8 bits of a transmit entry come out unchanged. For a receive entry, data sits in bits 7:0 and the error flags in bits 11:8.
- R5: A receive push while `rx_full` is 1 sets `overrun`. The flag stays set until `overrun_clr` is pulsed. When a set and a clear arrive in the same cycle, the set wins.
- R6: In queue mode, `rx_irq` is 1 exactly when the receive count is at or above its threshold. The threshold is chosen by `rx_lvl_sel`: code 0 gives 2 entries, 1 gives 4, 2 gives 8, 3 gives 12 and 4 gives 14. Codes 5 to 7 act as code 2. The reset code is 2.
- R7: In queue mode, `tx_irq` is 1 exactly when the transmit count is at or below the threshold chosen by `tx_lvl_sel`, using the same code table as R6.
- R8: In holding mode, both level selects have no effect. `rx_irq` equals "receive not empty" and `tx_irq` equals "transmit empty".
- R9: A change of `fifo_en` empties both queues at the next clock edge. Any push or pop presented in that cycle is ignored. The `overrun` flag is not affected.
- R10: A pop on an empty queue has no effect. A push and a pop in the same cycle on a queue that is neither empty nor full keep the count unchanged and keep the arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = 16-deep queue mode, 0 = one-entry holding mode |
| tx_lvl_sel | input | 3 | Transmit threshold code |
| rx_lvl_sel | input | 3 | Receive threshold code |
| tx_push | input | 1 | Write a character into the transmit queue |
| tx_wdata | input | 8 | Character to write |
| tx_pop | input | 1 | Remove the oldest transmit character |
| tx_rdata | output | 8 | Oldest transmit character |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_push | input | 1 | Write an entry into the receive queue |
| rx_wdata | input | 12 | Entry to write: flags in 11:8, data in 7:0 |
| rx_pop | input | 1 | Remove the oldest receive entry |
| rx_rdata | output | 12 | Oldest receive entry |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_irq | output | 1 | Receive interrupt request |
| overrun | output | 1 | Sticky flag: a receive entry was dropped |
| overrun_clr | input | 1 | Clears `overrun` |

## Verification
A wrong fill count shows up as an interrupt or full flag that turns at the wrong entry. The bench sweeps every threshold code one entry at a time, so an off-by-one appears on the very edge where the count is wrong. Pointer corruption shows on the read data port the first time the bad entry reaches the head of the queue, which is why each fill is drained with every value compared in order. A missed flush or a stale mode register shows in the cycle right after `fifo_en` changes, as a queue that still reports data or a holding queue that reports full at the wrong count.

// File: rtl/uart_fifo_pkg.sv
// Shared definitions for the paired UART queues.
// Assumes threshold codes are 3 bits wide. Unlisted codes fall back to the half mark.
package uart_fifo_pkg;

    localparam int unsigned LVL_W = 3;

    typedef enum logic [LVL_W-1:0] {
        LVL_EIGHTH       = 3'd0,
        LVL_QUARTER      = 3'd1,
        LVL_HALF         = 3'd2,
        LVL_THREE_QUART  = 3'd3,
        LVL_SEVEN_EIGHTH = 3'd4
    } lvl_code_e;

    // Number of eighths of the depth selected by a threshold code.
    function automatic int unsigned lvl_eighths(input logic [LVL_W-1:0] code);
        case (code)
            LVL_EIGHTH:       lvl_eighths = 1;
            LVL_QUARTER:      lvl_eighths = 2;
            LVL_HALF:         lvl_eighths = 4;
            LVL_THREE_QUART:  lvl_eighths = 6;
            LVL_SEVEN_EIGHTH: lvl_eighths = 7;
            default:          lvl_eighths = 4;
        endcase
    endfunction

endpackage

// File: rtl/ufp_store.sv
// Circular queue with a run-time capacity of DEPTH entries or 1 entry.
// The read side is show-ahead. Pushes into a full queue are dropped and
// flagged on push_drop. A flush empties the queue and blocks push and pop
// in that cycle.
// Assumes DEPTH >= 2. The storage is not reset; only the pointers and the count are.
module ufp_store #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             deep,
    input  logic                             flush,
    input  logic                             push,
    input  logic [WIDTH-1:0]                 wdata,
    input  logic                             pop,
    output logic [WIDTH-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]       count,
    output logic                             empty,
    output logic                             full,
    output logic                             push_drop
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    cap;
    logic             do_push;
    logic             do_pop;

    // Next pointer value, wrapping at the last slot.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        bump = (p == LAST_C) ? '0 : p + 1'b1;
    endfunction

    // Capacity and status flags from the current count.
    always_comb begin
        cap       = deep ? DEPTH_C : CW'(1);
        empty     = (count == '0);
        full      = (count == cap);
        do_push   = push && !full && !flush;
        do_pop    = pop && !empty && !flush;
        push_drop = push && full && !flush;
        rdata     = mem[rd_ptr];
    end

    // Storage write on accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and count update: flush, push, pop or both.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: the count never exceeds the capacity of the current mode.
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);

    // R3: in holding mode at most one entry is ever held.
    p_hold_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!deep && !$past(deep) && $past(rst_n)) |-> (count <= CW'(1)));

    // R2: a dropped push leaves a full queue full.
    p_drop_keeps_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full);

    // R10: a lone pop on an empty queue leaves it empty.
    p_pop_empty_noop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

    // R10: push and pop together on a partly filled queue keep the count.
    p_push_pop_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !full && !flush) |=> $stable(count));

    // R9: a flush leaves the queue empty.
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/ufp_level.sv
// Interrupt request for one direction of the queue pair.
// In queue mode the request compares the fill count against a threshold given
// in eighths of DEPTH. The receive variant asserts at or above the threshold,
// the transmit variant at or below it. In holding mode the threshold is unused:
// the receive variant follows "not empty" and the transmit variant follows "empty".
// Assumes count comes from a ufp_store of the same DEPTH.
module ufp_level
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter bit          IS_RX = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        deep,
    input  logic [LVL_W-1:0]            sel,
    input  logic [$clog2(DEPTH+1)-1:0]  count,
    output logic                        irq
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    int unsigned   thr_wide;
    logic [CW-1:0] thr;

    // Threshold in entries for the selected code.
    always_comb begin
        thr_wide = (DEPTH * lvl_eighths(sel)) >> 3;
        thr      = CW'(thr_wide);
    end

    // Direction-specific comparison, picked at elaboration.
    generate
        if (IS_RX) begin : g_rx
            always_comb begin
                irq = deep ? (count >= thr) : (count != '0);
            end
            // R6: a full receive queue always requests service.
            p_rx_full_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (deep && count == CW'(DEPTH)) |-> irq);
        end else begin : g_tx
            always_comb begin
                irq = deep ? (count <= thr) : (count == '0);
            end
            // R7: an empty transmit queue always requests data.
            p_tx_empty_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (count == '0) |-> irq);
        end
    endgenerate

endmodule

// File: rtl/uart_fifo_pair.sv
// Transmit and receive queues of a UART with a shared depth mode and
// per-direction interrupt thresholds. It holds the mode register, detects
// mode changes to flush both queues, and keeps the sticky receive overrun flag.
// Assumes the serial engines and the processor side obey the push/pop
// handshake; nothing is buffered at the ports.
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned TX_W      = 8,
    parameter int unsigned RX_DATA_W = 8,
    parameter int unsigned RX_FLAG_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fifo_en,
    input  logic [2:0]                    tx_lvl_sel,
    input  logic [2:0]                    rx_lvl_sel,
    input  logic                          tx_push,
    input  logic [TX_W-1:0]               tx_wdata,
    input  logic                          tx_pop,
    output logic [TX_W-1:0]               tx_rdata,
    output logic                          tx_empty,
    output logic                          tx_full,
    output logic                          tx_irq,
    input  logic                          rx_push,
    input  logic [RX_DATA_W+RX_FLAG_W-1:0] rx_wdata,
    input  logic                          rx_pop,
    output logic [RX_DATA_W+RX_FLAG_W-1:0] rx_rdata,
    output logic                          rx_empty,
    output logic                          rx_full,
    output logic                          rx_irq,
    output logic                          overrun,
    input  logic                          overrun_clr
);

    localparam int unsigned RX_W = RX_DATA_W + RX_FLAG_W;
    localparam int unsigned CW   = $clog2(DEPTH + 1);

    logic          mode_q;
    logic          flush;
    logic [CW-1:0] tx_count;
    logic [CW-1:0] rx_count;
    logic          tx_drop;
    logic          rx_drop;

    // A mode change is seen as a difference between the input and the register.
    always_comb begin
        flush = (fifo_en != mode_q);
    end

    // Mode register: holding mode out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= fifo_en;
        end
    end

    // Sticky overrun: a drop sets it, an explicit clear resets it, the set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (rx_drop) begin
            overrun <= 1'b1;
        end else if (overrun_clr) begin
            overrun <= 1'b0;
        end
    end

    ufp_store #(.WIDTH(TX_W), .DEPTH(DEPTH)) u_tx_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .deep      (mode_q),
        .flush     (flush),
        .push      (tx_push),
        .wdata     (tx_wdata),
        .pop       (tx_pop),
        .rdata     (tx_rdata),
        .count     (tx_count),
        .empty     (tx_empty),
        .full      (tx_full),
        .push_drop (tx_drop)
    );

    ufp_store #(.WIDTH(RX_W), .DEPTH(DEPTH)) u_rx_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .deep      (mode_q),
        .flush     (flush),
        .push      (rx_push),
        .wdata     (rx_wdata),
        .pop       (rx_pop),
        .rdata     (rx_rdata),
        .count     (rx_count),
        .empty     (rx_empty),
        .full      (rx_full),
        .push_drop (rx_drop)
    );

    ufp_level #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_level (
        .clk   (clk),
        .rst_n (rst_n),
        .deep  (mode_q),
        .sel   (tx_lvl_sel),
        .count (tx_count),
        .irq   (tx_irq)
    );

    ufp_level #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_level (
        .clk   (clk),
        .rst_n (rst_n),
        .deep  (mode_q),
        .sel   (rx_lvl_sel),
        .count (rx_count),
        .irq   (rx_irq)
    );

    // R5: a push into a full receive queue sets overrun.
    p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !flush) |=> overrun);

    // R5: overrun holds until an explicit clear.
    p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !overrun_clr) |=> overrun);

    // R9: a mode change empties both queues at the next edge.
    p_flush_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != mode_q) |=> (tx_empty && rx_empty));

    // R8: in holding mode a held receive entry always raises the request.
    p_hold_rx_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !rx_empty) |-> rx_irq);

    // R2: full and empty are never reported together.
    p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));

endmodule

// File: tb/uart_fifo_pair_tb.sv
module uart_fifo_pair_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fifo_en;
    logic [2:0]  tx_lvl_sel, rx_lvl_sel;
    logic        tx_push, tx_pop, rx_push, rx_pop, overrun_clr;
    logic [7:0]  tx_wdata, tx_rdata;
    logic [11:0] rx_wdata, rx_rdata;
    logic        tx_empty, tx_full, tx_irq, rx_empty, rx_full, rx_irq, overrun;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_pair u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .tx_lvl_sel(tx_lvl_sel), .rx_lvl_sel(rx_lvl_sel),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_empty(tx_empty), .tx_full(tx_full), .tx_irq(tx_irq),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_empty(rx_empty), .rx_full(rx_full), .rx_irq(rx_irq),
        .overrun(overrun), .overrun_clr(overrun_clr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int thr_of(input logic [2:0] code);
        case (code)
            3'd0: thr_of = 2;
            3'd1: thr_of = 4;
            3'd3: thr_of = 12;
            3'd4: thr_of = 14;
            default: thr_of = 8;
        endcase
    endfunction

    // Each stimulus starts just after a falling edge and lasts one cycle.
    task automatic cyc();
        @(negedge clk);
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; overrun_clr = 0;
    endtask

    task automatic rx_in(input logic [11:0] d);
        rx_push = 1; rx_wdata = d; cyc();
    endtask

    task automatic tx_in(input logic [7:0] d);
        tx_push = 1; tx_wdata = d; cyc();
    endtask

    task automatic set_mode(input logic en);
        fifo_en = en; cyc();
    endtask

    task automatic t_reset();
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 tx_full", tx_full, 0);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 tx_irq", tx_irq, 1);
        chk("R1 rx_irq", rx_irq, 0);
    endtask

    task automatic t_holding();
        tx_lvl_sel = 3'd4; rx_lvl_sel = 3'd4;  // R8: codes must not matter
        rx_in(12'hABC);
        chk("R3 rx_full after one", rx_full, 1);
        chk("R8 rx_irq not empty", rx_irq, 1);
        chk("R4 rx_rdata", rx_rdata, 12'hABC);
        rx_in(12'h123);
        chk("R3 second push dropped", rx_rdata, 12'hABC);
        chk("R5 overrun set", overrun, 1);
        rx_pop = 1; cyc();
        chk("R3 empty after pop", rx_empty, 1);
        chk("R8 rx_irq cleared", rx_irq, 0);
        chk("R5 overrun sticky", overrun, 1);
        overrun_clr = 1; cyc();
        chk("R5 overrun cleared", overrun, 0);
        tx_in(8'h5A);
        chk("R3 tx_full", tx_full, 1);
        chk("R8 tx_irq off when held", tx_irq, 0);
        chk("R4 tx_rdata", tx_rdata, 8'h5A);
        tx_pop = 1; cyc();
        chk("R8 tx_irq on empty", tx_irq, 1);
        tx_lvl_sel = 3'd2; rx_lvl_sel = 3'd2;
    endtask

    task automatic t_flush_on();
        rx_in(12'h777);
        tx_in(8'h11);
        overrun_clr = 0;
        rx_in(12'h001);  // sets overrun
        fifo_en = 1; tx_push = 1; tx_wdata = 8'h22; rx_pop = 1; cyc();
        chk("R9 rx flushed", rx_empty, 1);
        chk("R9 tx flushed, push ignored", tx_empty, 1);
        chk("R9 overrun kept", overrun, 1);
        overrun_clr = 1; cyc();
    endtask

    task automatic t_fill_rx();
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 rx not full early", rx_full, 0);
            rx_in(12'h800 + 12'(i * 17));
        end
        chk("R2 rx full at 16", rx_full, 1);
        chk("R5 no overrun yet", overrun, 0);
        rx_in(12'hFFF);
        chk("R5 overrun on 17th", overrun, 1);
        overrun_clr = 1; rx_push = 1; rx_wdata = 12'hEEE; cyc();
        chk("R5 set wins over clear", overrun, 1);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 R4 rx order", rx_rdata, 12'h800 + 12'(i * 17));
            rx_pop = 1; cyc();
        end
        chk("R2 rx empty after drain", rx_empty, 1);
        overrun_clr = 1; cyc();
    endtask

    task automatic t_fill_tx();
        for (int i = 0; i < DEPTH; i++) tx_in(8'(8'hC0 ^ i));
        chk("R2 tx full at 16", tx_full, 1);
        tx_in(8'h99);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 tx order", tx_rdata, 8'(8'hC0 ^ i));
            tx_pop = 1; cyc();
        end
        chk("R2 tx empty", tx_empty, 1);
    endtask

    task automatic t_rx_levels();
        for (int s = 0; s < 8; s++) begin
            rx_lvl_sel = 3'(s);
            for (int n = 0; n <= DEPTH; n++) begin
                chk($sformatf("R6 rx_irq sel=%0d n=%0d", s, n), rx_irq, (n >= thr_of(3'(s))) ? 1 : 0);
                if (n < DEPTH) rx_in(12'(n));
            end
            for (int n = 0; n < DEPTH; n++) begin rx_pop = 1; cyc(); end
        end
        rx_lvl_sel = 3'd1;
        for (int n = 0; n < 4; n++) rx_in(12'(n));
        chk("R6 quarter asserts at 4", rx_irq, 1);
        for (int n = 0; n < 4; n++) begin rx_pop = 1; cyc(); end
        rx_lvl_sel = 3'd2;
    endtask

    task automatic t_tx_levels();
        for (int s = 0; s < 8; s++) begin
            tx_lvl_sel = 3'(s);
            for (int n = 0; n <= DEPTH; n++) begin
                chk($sformatf("R7 tx_irq sel=%0d n=%0d", s, n), tx_irq, (n <= thr_of(3'(s))) ? 1 : 0);
                if (n < DEPTH) tx_in(8'(n));
            end
            for (int n = 0; n < DEPTH; n++) begin tx_pop = 1; cyc(); end
        end
        tx_lvl_sel = 3'd2;
    endtask

    task automatic t_push_pop();
        rx_pop = 1; cyc();
        chk("R10 pop on empty stays empty", rx_empty, 1);
        rx_in(12'h101); rx_in(12'h202); rx_in(12'h303);
        rx_push = 1; rx_wdata = 12'h404; rx_pop = 1; cyc();
        chk("R10 head after push+pop", rx_rdata, 12'h202);
        rx_pop = 1; cyc();
        chk("R10 order 2", rx_rdata, 12'h303);
        rx_pop = 1; cyc();
        chk("R10 order 3", rx_rdata, 12'h404);
        rx_pop = 1; cyc();
        chk("R10 count kept", rx_empty, 1);
    endtask

    task automatic t_flush_off();
        tx_in(8'h31); tx_in(8'h32);
        rx_in(12'h031);
        fifo_en = 0; rx_push = 1; rx_wdata = 12'h555; cyc();
        chk("R9 tx flushed on disable", tx_empty, 1);
        chk("R9 rx flushed on disable", rx_empty, 1);
        rx_in(12'h0AA);
        chk("R3 holding after disable", rx_full, 1);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 0; fifo_en = 0; tx_lvl_sel = 3'd2; rx_lvl_sel = 3'd2;
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; overrun_clr = 0;
        tx_wdata = '0; rx_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        t_reset();
        t_holding();
        t_flush_on();
        t_fill_rx();
        t_fill_tx();
        t_rx_levels();
        t_tx_levels();
        t_push_pop();
        t_flush_off();
        done = 1;
        report();
        $finish;
    end

endmodule